// File: doc/BRIEF.md
# Warp Issue Scheduler

This block picks, in every clock cycle, at most one warp out of the warps resident in an execution unit and presents it for instruction issue. Thread blocks are loaded into the unit by giving a starting warp slot and a thread count. The block then occupies as many consecutive warp slots as it needs, 32 threads per warp. When the thread count is not a multiple of 32, the last slot holds a partial warp, and the lanes that hold no thread are masked off. Individual warps leave when the surrounding logic retires them.

An operand tracker outside this block supplies one ready bit per warp slot. The bit says that the operands of that warp's next instruction are available. A warp is a candidate only when it is resident, its ready bit is set and it is not being retired in the same cycle. Among the candidates, the warp whose block was loaded earliest wins, and within a block the lowest slot number wins. The choice is registered, so the issue outputs reflect the candidates of the previous cycle. Because a new choice is made every cycle, the unit can move from one warp to another with no idle cycle between them.

Top module: `warp_issue_sched`

## Requirements
- R1: An accepted load of N threads (1 to MAX_BLOCK_THREADS) at starting slot b marks slots b to b+ceil(N/32)-1 resident from the next cycle. `resident_count` equals the number of resident slots: three 256-thread blocks give 24, and one 1024-thread block gives 32.
- R2: At most one warp is issued per cycle. `issue_warp` carries its slot number, and the outputs in cycle t+1 reflect the inputs and state of cycle t.
- R3: Slot i is eligible only when it is resident and `ready_vec[i]` is 1. A ready bit on a slot that is not resident is never issued.
- R4: Among eligible slots, a slot whose block was loaded in an earlier cycle wins over a slot loaded later. Between slots of equal age, the lowest slot number wins.
- R5: If any slot is eligible in cycle t, `issue_valid` is 1 in cycle t+1. Consecutive cycles may issue different warps with no gap between them.
- R6: If no slot is eligible in cycle t, `issue_valid` is 0 in cycle t+1.
- R7: A slot retired in cycle t is not eligible in cycle t or in any later cycle until it is loaded again. If a load covers the same slot in the same cycle as its retirement, the load wins and the slot stays resident.
- R8: `issue_mask` bit k is 1 when lane k of the issued warp holds a thread. For the last warp of a block with N mod 32 = r, where r is not 0, only bits 0 to r-1 are set. Every other warp has all 32 bits set.
- R9: While reset is held and after it is released, no slot is resident, `issue_valid` is 0 and `resident_count` is 0.
- R10: Slots that would lie at or beyond NUM_WARPS are dropped, and a load with a thread count of 0 changes nothing.
- R11: A slot that is loaded again becomes younger than every other resident slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_valid | input | 1 | Load a block this cycle |
| alloc_base | input | $clog2(NUM_WARPS) | First warp slot of the block |
| alloc_threads | input | $clog2(MAX_BLOCK_THREADS+1) | Thread count of the block |
| retire_valid | input | 1 | Retire one warp this cycle |
| retire_warp | input | $clog2(NUM_WARPS) | Slot of the warp being retired |
| ready_vec | input | NUM_WARPS | Operands-ready bit per slot |
| issue_valid | output | 1 | A warp is issued this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Slot of the issued warp |
| issue_mask | output | WARP_SIZE | Lanes of the issued warp that hold threads |
| resident_count | output | $clog2(NUM_WARPS+1) | Number of resident slots |

## Verification
The bench builds the block with its default parameters: 32 slots, 32-thread warps and blocks of up to 1024 threads. With these values the 3 × 256-thread case (24 warps) and the full 1024-thread case (32 warps) can both be reached, as can a load that runs past the last slot. The 40-thread and 128-thread blocks exercise partial-warp masks and slot truncation. A reference model based on load sequence numbers predicts each grant. It covers age ordering across blocks, lowest-slot ties within a block, a retirement and a load on the same slot in the same cycle, and the reload of a slot so that it becomes the youngest.

// File: rtl/wsched_pkg.sv
// Shared helpers for the warp issue scheduler.
// Assumes: arguments are non-negative and the divisor is non-zero.
package wsched_pkg;

    // Integer division rounded up; gives the number of warps a block needs.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/wsched_alloc_decode.sv
// Decodes a block load into per-slot hit bits and per-slot lane counts.
// Assumes: alloc_threads <= MAX_BLOCK_THREADS; slots past NUM_WARPS-1 are dropped.
module wsched_alloc_decode
    import wsched_pkg::*;
#(
    parameter int NUM_WARPS         = 32,
    parameter int WARP_SIZE         = 32,
    parameter int MAX_BLOCK_THREADS = 1024,
    localparam int ID_W   = $clog2(NUM_WARPS),
    localparam int THR_W  = $clog2(MAX_BLOCK_THREADS + 1),
    localparam int LANE_W = $clog2(WARP_SIZE + 1)
) (
    input  logic                             alloc_valid,
    input  logic [ID_W-1:0]                  alloc_base,
    input  logic [THR_W-1:0]                 alloc_threads,
    output logic [NUM_WARPS-1:0]             slot_hit,
    output logic [NUM_WARPS-1:0][LANE_W-1:0] slot_lanes
);
    localparam int OFS_W = THR_W + 1;

    logic [OFS_W-1:0] warp_span;
    logic [THR_W-1:0] tail_lanes;

    // Number of warps the block needs and the lane count of its last warp.
    always_comb begin
        warp_span  = OFS_W'(ceil_div(int'(alloc_threads), WARP_SIZE));
        tail_lanes = alloc_threads % THR_W'(WARP_SIZE);
    end

    for (genvar s = 0; s < NUM_WARPS; s++) begin : g_slot
        logic [OFS_W-1:0] ofs;
        // Offset of this slot from the first slot of the block.
        assign ofs = OFS_W'(s) - OFS_W'(alloc_base);
        // Slot is covered when it lies inside [base, base + span).
        assign slot_hit[s] = alloc_valid && (alloc_threads != '0) &&
                             (ID_W'(s) >= alloc_base) && (ofs < warp_span);
        // The last warp of a block with a remainder gets a partial lane count.
        assign slot_lanes[s] = ((ofs == warp_span - OFS_W'(1)) && (tail_lanes != '0))
                             ? LANE_W'(tail_lanes) : LANE_W'(WARP_SIZE);
    end

endmodule

// File: rtl/wsched_slot_table.sv
// Per-slot state: residency, lane count, and a pairwise load-age matrix.
// older_q[i][j] = 1 means slot i was loaded in an earlier cycle than slot j.
// Assumes: the matrix entries of non-resident slots are don't-care (eligibility masks them).
module wsched_slot_table #(
    parameter int NUM_WARPS = 32,
    parameter int LANE_W    = 6,
    localparam int ID_W     = $clog2(NUM_WARPS)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [NUM_WARPS-1:0]                slot_hit,
    input  logic [NUM_WARPS-1:0][LANE_W-1:0]    slot_lanes,
    input  logic                                retire_valid,
    input  logic [ID_W-1:0]                     retire_warp,
    output logic [NUM_WARPS-1:0]                resident,
    output logic [NUM_WARPS-1:0]                retire_hit,
    output logic [NUM_WARPS-1:0][LANE_W-1:0]    lanes,
    output logic [NUM_WARPS-1:0][NUM_WARPS-1:0] older
);
    logic [NUM_WARPS-1:0]                resident_q;
    logic [NUM_WARPS-1:0][LANE_W-1:0]    lanes_q;
    logic [NUM_WARPS-1:0][NUM_WARPS-1:0] older_q;

    for (genvar s = 0; s < NUM_WARPS; s++) begin : g_ret
        // One-hot decode of the retiring slot.
        assign retire_hit[s] = retire_valid && (retire_warp == ID_W'(s));
    end

    // Residency: retirement clears a slot, a load sets it and takes precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) resident_q <= '0;
        else        resident_q <= (resident_q & ~retire_hit) | slot_hit;
    end

    // Lane count captured on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lanes_q <= '0;
        end else begin
            for (int s = 0; s < NUM_WARPS; s++)
                if (slot_hit[s]) lanes_q[s] <= slot_lanes[s];
        end
    end

    // Age matrix: a freshly loaded slot is older than nobody, and everyone else is older than it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < NUM_WARPS; i++)
                for (int j = 0; j < NUM_WARPS; j++)
                    if (slot_hit[i])      older_q[i][j] <= 1'b0;
                    else if (slot_hit[j]) older_q[i][j] <= 1'b1;
        end
    end

    assign resident = resident_q;
    assign lanes    = lanes_q;
    assign older    = older_q;

    // R7: a retirement that no load overrides leaves the slot non-resident.
    p_retire_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && int'(retire_warp) < NUM_WARPS && !slot_hit[retire_warp])
        |=> !resident_q[$past(retire_warp)]);

    // R7: a load on the slot being retired keeps it resident.
    p_load_beats_retire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && int'(retire_warp) < NUM_WARPS && slot_hit[retire_warp])
        |=> resident_q[$past(retire_warp)]);

    // R1: every slot covered by a load is resident in the next cycle.
    p_load_resident_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|slot_hit) |=> ((resident_q & $past(slot_hit)) == $past(slot_hit)));

endmodule

// File: rtl/wsched_pick.sv
// Oldest-first arbiter over eligible slots; ties go to the lowest slot number.
// Assumes: older[][] is a consistent order among resident slots (slot table guarantees it).
module wsched_pick #(
    parameter int NUM_WARPS = 32,
    localparam int ID_W     = $clog2(NUM_WARPS)
) (
    input  logic [NUM_WARPS-1:0]                elig,
    input  logic [NUM_WARPS-1:0][NUM_WARPS-1:0] older,
    output logic [NUM_WARPS-1:0]                grant,
    output logic                                any,
    output logic [ID_W-1:0]                     grant_id
);
    logic [NUM_WARPS-1:0][NUM_WARPS-1:0] beats;

    for (genvar i = 0; i < NUM_WARPS; i++) begin : g_row
        for (genvar j = 0; j < NUM_WARPS; j++) begin : g_col
            // i wins over j when older, or when neither is older and i has the lower number.
            assign beats[i][j] = older[i][j] | (~older[j][i] & ((i <= j) ? 1'b1 : 1'b0));
        end
        // i is granted when it is eligible and wins over every other eligible slot.
        assign grant[i] = elig[i] & (&(~elig | beats[i]));
    end

    // Encode the one-hot grant into a slot number.
    always_comb begin
        grant_id = '0;
        for (int k = 0; k < NUM_WARPS; k++)
            if (grant[k]) grant_id = grant_id | ID_W'(k);
    end

    assign any = |elig;

endmodule

// File: rtl/warp_issue_sched.sv
// Warp issue scheduler top: loads blocks into warp slots, forms eligibility from
// residency and operand readiness, and registers one oldest-first grant per cycle.
// Assumes: ready_vec is valid every cycle; loads and retirements are single-cycle pulses.
module warp_issue_sched #(
    parameter int NUM_WARPS         = 32,
    parameter int WARP_SIZE         = 32,
    parameter int MAX_BLOCK_THREADS = 1024,
    localparam int ID_W   = $clog2(NUM_WARPS),
    localparam int THR_W  = $clog2(MAX_BLOCK_THREADS + 1),
    localparam int CNT_W  = $clog2(NUM_WARPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_valid,
    input  logic [ID_W-1:0]      alloc_base,
    input  logic [THR_W-1:0]     alloc_threads,
    input  logic                 retire_valid,
    input  logic [ID_W-1:0]      retire_warp,
    input  logic [NUM_WARPS-1:0] ready_vec,
    output logic                 issue_valid,
    output logic [ID_W-1:0]      issue_warp,
    output logic [WARP_SIZE-1:0] issue_mask,
    output logic [CNT_W-1:0]     resident_count
);
    localparam int LANE_W = $clog2(WARP_SIZE + 1);

    logic [NUM_WARPS-1:0]                slot_hit;
    logic [NUM_WARPS-1:0][LANE_W-1:0]    slot_lanes;
    logic [NUM_WARPS-1:0]                resident;
    logic [NUM_WARPS-1:0]                retire_hit;
    logic [NUM_WARPS-1:0][LANE_W-1:0]    lanes;
    logic [NUM_WARPS-1:0][NUM_WARPS-1:0] older;
    logic [NUM_WARPS-1:0]                elig_vec;
    logic [NUM_WARPS-1:0]                grant;
    logic                                grant_any;
    logic [ID_W-1:0]                     grant_id;
    logic [LANE_W-1:0]                   lanes_sel;
    logic [WARP_SIZE-1:0]                pick_mask;

    wsched_alloc_decode #(
        .NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .MAX_BLOCK_THREADS(MAX_BLOCK_THREADS)
    ) u_decode (
        .alloc_valid(alloc_valid), .alloc_base(alloc_base), .alloc_threads(alloc_threads),
        .slot_hit(slot_hit), .slot_lanes(slot_lanes)
    );

    wsched_slot_table #(.NUM_WARPS(NUM_WARPS), .LANE_W(LANE_W)) u_table (
        .clk(clk), .rst_n(rst_n), .slot_hit(slot_hit), .slot_lanes(slot_lanes),
        .retire_valid(retire_valid), .retire_warp(retire_warp),
        .resident(resident), .retire_hit(retire_hit), .lanes(lanes), .older(older)
    );

    // Eligible: resident, operands ready, and not leaving this cycle.
    assign elig_vec = resident & ready_vec & ~retire_hit;

    wsched_pick #(.NUM_WARPS(NUM_WARPS)) u_pick (
        .elig(elig_vec), .older(older), .grant(grant), .any(grant_any), .grant_id(grant_id)
    );

    // Expand the granted slot's lane count into a per-lane mask.
    always_comb begin
        lanes_sel = lanes[grant_id];
        for (int k = 0; k < WARP_SIZE; k++)
            pick_mask[k] = (k < int'(lanes_sel));
    end

    // Register the grant; a new choice every cycle gives back-to-back switching.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_valid <= 1'b0;
            issue_warp  <= '0;
            issue_mask  <= '0;
        end else begin
            issue_valid <= grant_any;
            issue_warp  <= grant_id;
            issue_mask  <= pick_mask;
        end
    end

    assign resident_count = CNT_W'($countones(resident));

    // Previous-cycle eligibility, kept only to relate the grant to its cause.
    logic [NUM_WARPS-1:0] elig_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) elig_prev <= '0;
        else        elig_prev <= elig_vec;
    end

    // R2: the arbiter never grants two slots at once.
    p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R3: an issued warp was eligible in the cycle before.
    p_issue_eligible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> elig_prev[issue_warp]);

    // R5: any eligible slot leads to an issue in the next cycle.
    p_no_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig_prev) |-> issue_valid);

    // R6: with nothing eligible the valid strobe stays low.
    p_idle_when_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|elig_prev) |-> !issue_valid);

    // R8: an issued warp always has lane 0 populated.
    p_mask_lane0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> issue_mask[0]);

endmodule

// File: tb/warp_issue_sched_tb.sv
module warp_issue_sched_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW  = 32;
    localparam int WS  = 32;
    localparam int MB  = 1024;
    localparam int IDW = $clog2(NW);
    localparam int THW = $clog2(MB + 1);
    localparam int CW  = $clog2(NW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 1'b0;
    logic [IDW-1:0] alloc_base = '0;
    logic [THW-1:0] alloc_threads = '0;
    logic retire_valid = 1'b0;
    logic [IDW-1:0] retire_warp = '0;
    logic [NW-1:0] ready_vec = '0;
    logic issue_valid;
    logic [IDW-1:0] issue_warp;
    logic [WS-1:0] issue_mask;
    logic [CW-1:0] resident_count;

    always #(CLK_PERIOD/2) clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .WARP_SIZE(WS), .MAX_BLOCK_THREADS(MB)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_base(alloc_base),
        .alloc_threads(alloc_threads), .retire_valid(retire_valid), .retire_warp(retire_warp),
        .ready_vec(ready_vec), .issue_valid(issue_valid), .issue_warp(issue_warp),
        .issue_mask(issue_mask), .resident_count(resident_count)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit reported = 0;

    typedef struct {
        int          due;
        bit          v;
        int          id;
        logic [WS-1:0] m;
        int          cnt;
        string       tag;
    } exp_t;
    exp_t sb_q[$];

    // Reference model state
    bit m_res[NW];
    int m_lanes[NW];
    int m_stamp[NW];
    int m_seq = 0;

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    function automatic logic [NW-1:0] bit_of(input int i);
        return NW'(1) << i;
    endfunction

    // Driver: apply one cycle of stimulus, predict its outcome, push to the scoreboard.
    task automatic step(input bit av, input int base, input int thr,
                        input bit rv, input int rw, input logic [NW-1:0] rdy, input string tag);
        exp_t e;
        int best;
        @(negedge clk);
        alloc_valid = av; alloc_base = IDW'(base); alloc_threads = THW'(thr);
        retire_valid = rv; retire_warp = IDW'(rw); ready_vec = rdy;
        best = -1;
        for (int i = 0; i < NW; i++) begin
            if (m_res[i] && rdy[i] && !(rv && rw == i)) begin
                if (best < 0 || m_stamp[i] < m_stamp[best]) best = i;
            end
        end
        e.v = (best >= 0);
        e.id = (best >= 0) ? best : 0;
        e.m = '0;
        if (best >= 0)
            for (int k = 0; k < WS; k++) e.m[k] = (k < m_lanes[best]);
        if (rv) m_res[rw] = 0;
        if (av && thr > 0) begin
            int nw;
            nw = (thr + WS - 1) / WS;
            for (int k = 0; k < nw; k++) begin
                if (base + k < NW) begin
                    m_res[base + k] = 1;
                    m_lanes[base + k] = (k == nw - 1 && (thr % WS) != 0) ? (thr % WS) : WS;
                    m_stamp[base + k] = m_seq;
                end
            end
            m_seq++;
        end
        e.cnt = 0;
        for (int i = 0; i < NW; i++) e.cnt += int'(m_res[i]);
        e.due = cyc + 1;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare each due item against the outputs.
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            exp_t e;
            e = sb_q.pop_front();
            chk(issue_valid == e.v, {e.tag, " valid"}, longint'(issue_valid), longint'(e.v));
            if (e.v) begin
                chk(int'(issue_warp) == e.id, {e.tag, " R2 warp id"}, longint'(issue_warp), longint'(e.id));
                chk(issue_mask == e.m, {e.tag, " R8 mask"}, longint'(issue_mask), longint'(e.m));
            end
            chk(int'(resident_count) == e.cnt, {e.tag, " R1 count"}, longint'(resident_count), longint'(e.cnt));
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired before completion");
        report();
        $finish;
    end

    initial begin
        for (int i = 0; i < NW; i++) begin m_res[i] = 0; m_lanes[i] = 0; m_stamp[i] = 0; end
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(issue_valid == 1'b0, "R9 valid in reset", longint'(issue_valid), 0);
        chk(resident_count == '0, "R9 count in reset", longint'(resident_count), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(issue_valid == 1'b0, "R9 valid after reset", longint'(issue_valid), 0);
        chk(resident_count == '0, "R9 count after reset", longint'(resident_count), 0);

        // R1: three 256-thread blocks
        step(1, 0, 256, 0, 0, '0, "R1 R6 load A");
        step(1, 8, 256, 0, 0, '0, "R1 load B");
        step(1, 16, 256, 0, 0, '1, "R3 R4 all ready");
        step(0, 0, 0, 0, 0, '1, "R1 R4 24 warps");
        step(0, 0, 0, 0, 0, bit_of(8) | bit_of(20), "R4 older block");
        step(0, 0, 0, 0, 0, bit_of(20), "R3 single ready");
        step(0, 0, 0, 0, 0, bit_of(3) | bit_of(6), "R4 tie lowest");
        // R5: back-to-back switching
        step(0, 0, 0, 0, 0, bit_of(3), "R5 switch a");
        step(0, 0, 0, 0, 0, bit_of(9), "R5 switch b");
        step(0, 0, 0, 0, 0, bit_of(3), "R5 switch c");
        step(0, 0, 0, 0, 0, bit_of(9), "R5 switch d");
        step(0, 0, 0, 0, 0, 32'hFF00_0000, "R3 R6 non-resident ready");
        // R7: retirement
        step(0, 0, 0, 1, 0, bit_of(0) | bit_of(1), "R7 retire same cycle");
        step(0, 0, 0, 0, 0, bit_of(0), "R7 retired stays out");
        // R11 / R8: reload slots 0..1 with 40 threads
        step(1, 0, 40, 0, 0, bit_of(0), "R7 R11 reload");
        step(0, 0, 0, 0, 0, bit_of(0) | bit_of(5), "R11 reloaded is youngest");
        step(0, 0, 0, 0, 0, bit_of(1), "R8 partial warp");
        step(0, 0, 0, 0, 0, bit_of(0), "R8 full warp");
        // R10: ignored and truncated loads
        step(1, 24, 0, 0, 0, bit_of(0), "R10 zero-thread load");
        step(1, 30, 128, 0, 0, '0, "R10 truncated load");
        step(0, 0, 0, 0, 0, bit_of(31), "R10 last slot");
        // R7: load and retire on the same slot
        step(1, 2, 32, 1, 2, bit_of(2), "R7 load beats retire");
        step(0, 0, 0, 0, 0, bit_of(2) | bit_of(4), "R7 R11 slot kept");
        // R1: retire everything, then a 1024-thread block
        for (int i = 0; i < NW; i++) step(0, 0, 0, 1, i, '0, "R7 drain");
        step(1, 0, 1024, 0, 0, '0, "R1 full block");
        step(0, 0, 0, 0, 0, '1, "R1 R4 32 warps");
        step(0, 0, 0, 0, 0, bit_of(7) | bit_of(4), "R4 same block tie");
        step(0, 0, 0, 0, 0, '0, "R6 idle");
        step(0, 0, 0, 0, 0, '0, "R6 idle");
        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule